// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This unit takes one conditional-branch instruction word, the address of that instruction, and the two source operand values. It returns the branch outcome one clock later. It decodes the comparison selector, the two source register indices and the split immediate field. It evaluates one of six signed or unsigned comparisons. It then produces the next program counter, which is either the branch target or the address of the following instruction.

A taken branch whose target is not on a four-byte boundary raises an instruction-address-misaligned exception, but only when compressed instructions are disabled. On an exception the faulting target is reported as a trap value, the program counter is held, and the instruction does not retire. When compressed instructions are enabled, a two-byte-aligned target is accepted. A branch that is not taken is never checked for alignment. Encodings that are not valid branches are flagged as illegal.

The execute stage of a pipeline uses the unit by pulsing `in_valid` with the operands already read. Register-file access, instruction fetch and trap entry belong to neighbouring blocks.

Top module: `br_resolve_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every output is cleared to zero on that edge.
- R2: Outputs reflect the inputs sampled on the edge where `in_valid` is high, from that edge onward. On an edge where `in_valid` is low, `out_valid` and every flag, index and address output clear to zero.
- R3: `src1_idx` carries instruction bits 19:15 and `src2_idx` carries bits 24:20.
- R4: The comparison is chosen by instruction bits 14:12, with `src_a` on the left of the comparison:
  - 000: equal
  - 001: not equal
  - 100: signed less-than
  - 101: signed greater-or-equal
  - 110: unsigned less-than
  - 111: unsigned greater-or-equal
- R5: The immediate is formed with bit 12 from instr[31], bit 11 from instr[7], bits 10:5 from instr[30:25], bits 4:1 from instr[11:8], and bit 0 as zero. It is sign-extended to XLEN. For a taken branch with an acceptable target, `next_pc` = `pc` + immediate, `taken` = 1 and `retire_ok` = 1.
- R6: For a branch that is not taken, the results are:
  - `next_pc` = `pc` + 4
  - `taken` = 0
  - `retire_ok` = 1
  - `misalign_exc` = 0, whatever the target's alignment.
- R7: For a taken branch whose target has bit 1 set while `compressed_en` is 0, the results are:
  - `misalign_exc` = 1
  - `trap_value` = target
  - `next_pc` = `pc`
  - `retire_ok` = 0
  - `taken` = 1
- R8: While `compressed_en` is 1, no alignment exception is raised, and a target with bit 1 set becomes `next_pc`.
- R9: An opcode (bits 6:0) other than 1100011, or a selector of 010 or 011, sets `illegal`. The unit then gives `taken` = 0, `retire_ok` = 0, `misalign_exc` = 0 and `next_pc` = `pc`.
- R10: `trap_value` is zero whenever `misalign_exc` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A branch is presented this cycle |
| instr | input | 32 | Instruction word |
| pc | input | XLEN | Address of the branch instruction |
| src_a | input | XLEN | Value of the first source register |
| src_b | input | XLEN | Value of the second source register |
| compressed_en | input | 1 | Compressed instructions are supported |
| out_valid | output | 1 | Registered results are valid |
| taken | output | 1 | Branch condition held |
| next_pc | output | XLEN | Resolved next program counter |
| misalign_exc | output | 1 | Instruction-address-misaligned exception |
| trap_value | output | XLEN | Faulting target address |
| illegal | output | 1 | Encoding is not a valid branch |
| retire_ok | output | 1 | Instruction retired successfully |
| src1_idx | output | 5 | First source register index |
| src2_idx | output | 5 | Second source register index |

## Verification
The bench pairs signed and unsigned comparisons on operands whose sign bits differ, such as all-ones against one. A design that mixes up the two kinds of comparison gives the opposite taken result for those pairs. The immediate is tested at its extremes of -4096 and +4094. A wrong placement of any scattered bit or a missing sign extension then gives a wrong `next_pc`. A target with bit 1 set is sent three ways: as a taken branch with compressed instructions off, as a not-taken branch, and as a taken branch with compressed instructions on. A design that checks alignment regardless of the outcome, or ignores `compressed_en`, raises a false exception or misses a real one. Illegal selectors and a foreign opcode are also sent, to catch a design that still retires such words or moves the program counter.

// File: rtl/br_pkg.sv
package br_pkg;
    typedef enum logic [2:0] {
        CMP_EQ  = 3'b000,
        CMP_NE  = 3'b001,
        CMP_BAD2 = 3'b010,
        CMP_BAD3 = 3'b011,
        CMP_LT  = 3'b100,
        CMP_GE  = 3'b101,
        CMP_LTU = 3'b110,
        CMP_GEU = 3'b111
    } br_cond_e;

    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam int IMM_W = 13;
    localparam int REG_IDX_W = 5;
endpackage

// File: rtl/br_decode.sv
module br_decode
    import br_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [31:0]           instr,
    output br_cond_e              cond,
    output logic [XLEN-1:0]       imm_sx,
    output logic [REG_IDX_W-1:0]  rs1_idx,
    output logic [REG_IDX_W-1:0]  rs2_idx,
    output logic                  bad_enc
);
    logic [IMM_W-1:0] imm_raw;

    always_comb begin
        imm_raw = {instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};
        imm_sx  = {{(XLEN-IMM_W){imm_raw[IMM_W-1]}}, imm_raw};
        rs1_idx = instr[19:15];
        rs2_idx = instr[24:20];
        cond    = br_cond_e'(instr[14:12]);
        bad_enc = (instr[6:0] != OPC_BRANCH) ||
                  (instr[14:12] == CMP_BAD2) || (instr[14:12] == CMP_BAD3);
    end
endmodule

// File: rtl/br_compare.sv
module br_compare
    import br_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] lhs,
    input  logic [XLEN-1:0] rhs,
    input  br_cond_e        cond,
    output logic            hit
);
    logic is_eq, is_lt_s, is_lt_u;

    always_comb begin
        is_eq   = (lhs == rhs);
        is_lt_s = ($signed(lhs) < $signed(rhs));
        is_lt_u = (lhs < rhs);
        unique case (cond)
            CMP_EQ:  hit = is_eq;
            CMP_NE:  hit = !is_eq;
            CMP_LT:  hit = is_lt_s;
            CMP_GE:  hit = !is_lt_s;
            CMP_LTU: hit = is_lt_u;
            CMP_GEU: hit = !is_lt_u;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/br_target.sv
module br_target #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] offset,
    input  logic            compressed_en,
    output logic [XLEN-1:0] target,
    output logic [XLEN-1:0] seq_pc,
    output logic            bad_align
);
    localparam logic [XLEN-1:0] INSTR_BYTES = XLEN'(4);

    always_comb begin
        target    = pc + offset;
        seq_pc    = pc + INSTR_BYTES;
        bad_align = target[1] && !compressed_en;
    end
endmodule

// File: rtl/br_resolve_unit.sv
module br_resolve_unit
    import br_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [31:0]      instr,
    input  logic [XLEN-1:0]  pc,
    input  logic [XLEN-1:0]  src_a,
    input  logic [XLEN-1:0]  src_b,
    input  logic             compressed_en,
    output logic             out_valid,
    output logic             taken,
    output logic [XLEN-1:0]  next_pc,
    output logic             misalign_exc,
    output logic [XLEN-1:0]  trap_value,
    output logic             illegal,
    output logic             retire_ok,
    output logic [4:0]       src1_idx,
    output logic [4:0]       src2_idx
);
    typedef struct packed {
        logic                 vld;
        logic                 tkn;
        logic                 exc;
        logic                 ill;
        logic                 ret;
        logic [XLEN-1:0]      npc;
        logic [XLEN-1:0]      tval;
        logic [REG_IDX_W-1:0] rs1;
        logic [REG_IDX_W-1:0] rs2;
    } res_t;

    br_cond_e               cond;
    logic [XLEN-1:0]        imm_sx, target, seq_pc;
    logic [REG_IDX_W-1:0]   rs1_idx, rs2_idx;
    logic                   bad_enc, hit, bad_align;
    res_t                   res_d, res_q;

    br_decode #(.XLEN(XLEN)) u_dec (
        .instr(instr), .cond(cond), .imm_sx(imm_sx),
        .rs1_idx(rs1_idx), .rs2_idx(rs2_idx), .bad_enc(bad_enc)
    );

    br_compare #(.XLEN(XLEN)) u_cmp (
        .lhs(src_a), .rhs(src_b), .cond(cond), .hit(hit)
    );

    br_target #(.XLEN(XLEN)) u_tgt (
        .pc(pc), .offset(imm_sx), .compressed_en(compressed_en),
        .target(target), .seq_pc(seq_pc), .bad_align(bad_align)
    );

    always_comb begin
        res_d = '0;
        if (in_valid) begin
            res_d.vld = 1'b1;
            res_d.rs1 = rs1_idx;
            res_d.rs2 = rs2_idx;
            if (bad_enc) begin
                res_d.ill = 1'b1;
                res_d.npc = pc;
            end else if (!hit) begin
                res_d.npc = seq_pc;
                res_d.ret = 1'b1;
            end else if (bad_align) begin
                res_d.tkn  = 1'b1;
                res_d.exc  = 1'b1;
                res_d.tval = target;
                res_d.npc  = pc;
            end else begin
                res_d.tkn = 1'b1;
                res_d.npc = target;
                res_d.ret = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign out_valid    = res_q.vld;
    assign taken        = res_q.tkn;
    assign next_pc      = res_q.npc;
    assign misalign_exc = res_q.exc;
    assign trap_value   = res_q.tval;
    assign illegal      = res_q.ill;
    assign retire_ok    = res_q.ret;
    assign src1_idx     = res_q.rs1;
    assign src2_idx     = res_q.rs2;

    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !(taken || misalign_exc || illegal || retire_ok));

    assert_exc_outcome_R7: assert property (@(posedge clk) disable iff (rst)
        misalign_exc |-> (taken && !retire_ok && !illegal));

    assert_no_exc_compressed_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && compressed_en) |=> !misalign_exc);

    assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!taken && !retire_ok && !misalign_exc));

    assert_tval_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !misalign_exc |-> (trap_value == '0));
endmodule

// File: tb/br_resolve_unit_test.sv
module br_resolve_unit_test;
    localparam int XL = 32;
    localparam logic [6:0] OPC = 7'b1100011;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [31:0]   instr = '0;
    logic [XL-1:0] pc = '0, src_a = '0, src_b = '0;
    logic          compressed_en = 1'b0;
    logic          out_valid, taken, misalign_exc, illegal, retire_ok;
    logic [XL-1:0] next_pc, trap_value;
    logic [4:0]    src1_idx, src2_idx;

    int checks = 0;
    int errors = 0;

    br_resolve_unit #(.XLEN(XL)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .pc(pc),
        .src_a(src_a), .src_b(src_b), .compressed_en(compressed_en),
        .out_valid(out_valid), .taken(taken), .next_pc(next_pc),
        .misalign_exc(misalign_exc), .trap_value(trap_value), .illegal(illegal),
        .retire_ok(retire_ok), .src1_idx(src1_idx), .src2_idx(src2_idx)
    );

    always #10 clk = ~clk;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(logic [12:0] imm, logic [4:0] r2, logic [4:0] r1,
                                        logic [2:0] f3, logic [6:0] opc);
        return {imm[12], imm[10:5], r2, r1, f3, imm[4:1], imm[11], opc};
    endfunction

    function automatic logic [XL-1:0] sx(logic [12:0] imm);
        return {{(XL-13){imm[12]}}, imm};
    endfunction

    task automatic issue(logic [31:0] w, logic [XL-1:0] p, logic [XL-1:0] a,
                         logic [XL-1:0] b, logic cen);
        @(negedge clk);
        instr = w; pc = p; src_a = a; src_b = b; compressed_en = cen; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_branch(string req, logic [2:0] f3, logic [12:0] imm,
                                 logic [XL-1:0] p, logic [XL-1:0] a, logic [XL-1:0] b,
                                 logic cen, logic exp_tkn);
        logic [XL-1:0] tgt;
        tgt = p + sx(imm);
        issue(enc(imm, 5'd7, 5'd3, f3, OPC), p, a, b, cen);
        chk(req, "out_valid", 64'(out_valid), 64'd1);
        chk(req, "taken", 64'(taken), 64'(exp_tkn));
        chk(req, "retire_ok", 64'(retire_ok), 64'd1);
        chk(req, "next_pc", 64'(next_pc), exp_tkn ? 64'(tgt) : 64'(p + 32'd4));
        chk(req, "misalign_exc", 64'(misalign_exc), 64'd0);
    endtask

    task automatic t_reset;
        chk("R1", "out_valid", 64'(out_valid), 64'd0);
        chk("R1", "next_pc", 64'(next_pc), 64'd0);
        chk("R1", "retire_ok", 64'(retire_ok), 64'd0);
        chk("R1", "taken", 64'(taken), 64'd0);
    endtask

    task automatic t_conditions;
        expect_branch("R4 eq", 3'b000, 13'd16, 32'h100, 32'd5, 32'd5, 1'b0, 1'b1);
        expect_branch("R4 ne", 3'b001, 13'd16, 32'h100, 32'd5, 32'd5, 1'b0, 1'b0);
        expect_branch("R4 lt", 3'b100, 13'd16, 32'h100, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b1);
        expect_branch("R4 ge", 3'b101, 13'd16, 32'h100, 32'hFFFF_FFFB, 32'hFFFF_FFFB, 1'b0, 1'b1);
        expect_branch("R4 ge2", 3'b101, 13'd16, 32'h100, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0);
        expect_branch("R4 ltu", 3'b110, 13'd16, 32'h100, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0);
        expect_branch("R4 geu", 3'b111, 13'd16, 32'h100, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b1);
    endtask

    task automatic t_immediate;
        expect_branch("R5 min", 3'b000, 13'h1000, 32'h1000, 32'd0, 32'd0, 1'b0, 1'b1);
        expect_branch("R5 max", 3'b000, 13'h0FFC, 32'h1000, 32'd0, 32'd0, 1'b0, 1'b1);
        expect_branch("R5 r8_top", 3'b000, 13'h0FFE, 32'h1000, 32'd0, 32'd0, 1'b1, 1'b1);
        issue(enc(13'h0A8C, 5'd29, 5'd18, 3'b000, OPC), 32'h2000, 32'd1, 32'd1, 1'b0);
        chk("R3", "src1_idx", 64'(src1_idx), 64'd18);
        chk("R3", "src2_idx", 64'(src2_idx), 64'd29);
        chk("R5", "next_pc", 64'(next_pc), 64'(32'h2000 + 32'h0A8C));
    endtask

    task automatic t_alignment;
        issue(enc(13'd6, 5'd1, 5'd2, 3'b000, OPC), 32'h100, 32'd9, 32'd9, 1'b0);
        chk("R7", "misalign_exc", 64'(misalign_exc), 64'd1);
        chk("R7", "trap_value", 64'(trap_value), 64'h106);
        chk("R7", "next_pc", 64'(next_pc), 64'h100);
        chk("R7", "retire_ok", 64'(retire_ok), 64'd0);
        chk("R7", "taken", 64'(taken), 64'd1);
        issue(enc(13'd6, 5'd1, 5'd2, 3'b001, OPC), 32'h100, 32'd9, 32'd9, 1'b0);
        chk("R6", "misalign_exc", 64'(misalign_exc), 64'd0);
        chk("R6", "next_pc", 64'(next_pc), 64'h104);
        chk("R10", "trap_value", 64'(trap_value), 64'd0);
        issue(enc(13'd6, 5'd1, 5'd2, 3'b000, OPC), 32'h100, 32'd9, 32'd9, 1'b1);
        chk("R8", "misalign_exc", 64'(misalign_exc), 64'd0);
        chk("R8", "next_pc", 64'(next_pc), 64'h106);
        chk("R8", "retire_ok", 64'(retire_ok), 64'd1);
    endtask

    task automatic t_illegal;
        issue(enc(13'd8, 5'd1, 5'd2, 3'b010, OPC), 32'h300, 32'd0, 32'd0, 1'b0);
        chk("R9 f3=010", "illegal", 64'(illegal), 64'd1);
        chk("R9 f3=010", "retire_ok", 64'(retire_ok), 64'd0);
        chk("R9 f3=010", "next_pc", 64'(next_pc), 64'h300);
        issue(enc(13'd8, 5'd1, 5'd2, 3'b011, OPC), 32'h300, 32'd0, 32'd1, 1'b0);
        chk("R9 f3=011", "illegal", 64'(illegal), 64'd1);
        issue(enc(13'd8, 5'd1, 5'd2, 3'b000, 7'b0010011), 32'h300, 32'd4, 32'd4, 1'b0);
        chk("R9 opcode", "illegal", 64'(illegal), 64'd1);
        chk("R9 opcode", "taken", 64'(taken), 64'd0);
        chk("R9 opcode", "next_pc", 64'(next_pc), 64'h300);
    endtask

    task automatic t_idle;
        issue(enc(13'd6, 5'd1, 5'd2, 3'b000, OPC), 32'h100, 32'd9, 32'd9, 1'b0);
        chk("R2", "out_valid after strobe", 64'(out_valid), 64'd1);
        @(negedge clk);
        chk("R2", "out_valid idle", 64'(out_valid), 64'd0);
        chk("R2", "misalign_exc idle", 64'(misalign_exc), 64'd0);
        chk("R2", "next_pc idle", 64'(next_pc), 64'd0);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_conditions();
        t_immediate();
        t_alignment();
        t_illegal();
        t_idle();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule